// File: doc/BRIEF.md
# FIFO-Side Block Transfer Channel

This block is one direct-memory-access channel that moves a run of words between system memory and an external device fronted by a FIFO. Software sets a starting memory address, a word count, two 4-bit page numbers (one for the memory side when it is read, one for when it is written) and a control word. The control word picks the direction, the device width and one of three ways of sharing the system bus. It also carries a start bit. The channel then walks the block one word at a time. After each memory word it advances the address by one and lowers the remaining count by one. When the count reaches zero it gives the bus back and raises a one-cycle completion pulse.

With a byte-wide device, the channel makes two FIFO accesses per memory word. When reading from the device it builds a word from two bytes, taking the low byte first. When writing to the device it splits each word into two bytes, sending the low byte first. There are three bus-sharing policies. Burst holds the bus for the whole block. Cycle stealing takes the bus once per word. Interleaved never asks for the bus and touches memory only in cycles the processor marks as idle.

Top module: `dmaio_chan`

## Requirements
- R1: Register writes use `regSel`. Select 0 loads the address, select 1 loads the word count, and select 2 loads the control word. The control word fields are: bits [3:0] read-side page, bits [7:4] write-side page, bits [9:8] policy, bit 10 direction (0 = device to memory, 1 = memory to device), bit 11 byte-wide device, and bit 15 start. While `busy` is high, every register write is ignored.
- R2: If the word count is zero when start is written, the channel raises `done` without ever asserting `busReq`. No memory or device access takes place.
- R3: Each memory strobe is followed by an address one higher in the next cycle. The block fills consecutive addresses from the programmed start. A later transfer that does not reload the address carries on at the next address.
- R4: Policy 00 (burst), and policy 11 treated the same way, makes exactly one bus tenure per block. `busOwn` stays high from the grant until the block finishes.
- R5: Policy 01 (cycle stealing) makes one tenure per word. `stealReq` is high only while a request is active under this policy.
- R6: Policy 10 (interleaved) never asserts `busReq`. It strobes memory only in cycles where `cpuIdle` is high.
- R7: Under burst and cycle stealing, a memory strobe occurs only while both `busOwn` and `busGrant` are high.
- R8: During memory writes `memPage` shows the write-side page. During memory reads it shows the read-side page.
- R9: With a word-wide device, each memory word takes exactly one FIFO access and the whole word passes unchanged.
- R10: With a byte-wide device reading into memory, two reads form one word. The first `ioRdata[7:0]` becomes bits [7:0] and the second becomes bits [15:8].
- R11: With a byte-wide device written from memory, two writes carry one word, low byte first then high byte, each in `ioWdata[7:0]` with the upper byte zero.
- R12: `ioRd` and `ioWr` pulse only in a cycle where `ioReady` is high, and never both in the same cycle.
- R13: After reset, and again when a block ends, `busy`, `busReq` and `busOwn` are low. Each start produces `done` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWdata | input | DATA_W | Register write data |
| busReq | output | 1 | Bus request to the processor |
| busGrant | input | 1 | Bus granted by the processor |
| busOwn | output | 1 | High while the channel holds the bus |
| stealReq | output | 1 | Marks a request as a single-word steal |
| cpuIdle | input | 1 | Processor leaves the bus unused this cycle |
| memAddr | output | ADDR_W | Memory word address |
| memPage | output | 4 | Memory page number |
| memRe | output | 1 | Memory read strobe; data is expected on `memRdata` in the next cycle |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data |
| ioReady | input | 1 | FIFO not empty (reading) or not full (writing) |
| ioRd | output | 1 | FIFO read strobe |
| ioWr | output | 1 | FIFO write strobe |
| ioWdata | output | DATA_W | FIFO write data |
| ioRdata | input | DATA_W | FIFO read data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same clock edge: a software register write and the final memory write of a block, which is the access that ends the transfer. The bench provokes this by watching for the fourth write strobe of a four-word burst. It drives an address write so that the write is sampled on that same edge. It judges the result in two ways. First, a guard location at the written address must stay untouched. Second, a follow-up transfer that reloads only the count and control must land right after the first block. Together these show the write was discarded while `busy` was still high, and that the address kept its final increment.

// File: rtl/dmaio_pkg.sv
`timescale 1ns/1ps
package dmaio_pkg;

  localparam int PAGE_W = 4;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_SIZE = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CF_RPAGE = 0;
  localparam int CF_WPAGE = 4;
  localparam int CF_MODE  = 8;
  localparam int CF_DIR   = 10;
  localparam int CF_BYTE  = 11;
  localparam int CF_START = 15;

  typedef enum logic [1:0] {
    XM_BURST = 2'b00,
    XM_STEAL = 2'b01,
    XM_IDLE  = 2'b10,
    XM_ALT   = 2'b11
  } xferMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_REQ,
    ST_MEM,
    ST_CAP,
    ST_IO
  } chanState_e;

  typedef struct packed {
    logic advance;
    logic capMem;
    logic capIo;
    logic byteHi;
    logic cfgWrEn;
  } dpStrobe_t;

endpackage

// File: rtl/dmaio_datapath.sv
`timescale 1ns/1ps
module dmaio_datapath
  import dmaio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] ioRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PAGE_W-1:0] memPage,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] ioWdata,
  output logic              sizeIsZero,
  output logic              sizeIsOne,
  output xferMode_e         cfgMode,
  output logic              cfgMemToIo,
  output logic              cfgByteDev,
  output logic [PAGE_W-1:0] readPage,
  output logic [PAGE_W-1:0] writePage
);

  localparam int BYTE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  sizeQ;
  logic [DATA_W-1:0] holdQ;
  logic [PAGE_W-1:0] rPageQ, wPageQ;
  xferMode_e         modeQ;
  logic              dirQ, byteQ;
  logic [BYTE_W-1:0] outByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      holdQ  <= '0;
      rPageQ <= '0;
      wPageQ <= '0;
      modeQ  <= XM_BURST;
      dirQ   <= 1'b0;
      byteQ  <= 1'b0;
    end else begin
      if (regWe && stb.cfgWrEn) begin
        case (regSel)
          SEL_ADDR: addrQ <= ADDR_W'(regWdata);
          SEL_SIZE: sizeQ <= CNT_W'(regWdata);
          SEL_CTRL: begin
            rPageQ <= regWdata[CF_RPAGE +: PAGE_W];
            wPageQ <= regWdata[CF_WPAGE +: PAGE_W];
            modeQ  <= xferMode_e'(regWdata[CF_MODE +: 2]);
            dirQ   <= regWdata[CF_DIR];
            byteQ  <= regWdata[CF_BYTE];
          end
          default: ;
        endcase
      end
      if (stb.advance) begin
        addrQ <= addrQ + ADDR_W'(1);
        sizeQ <= sizeQ - CNT_W'(1);
      end
      if (stb.capMem) begin
        holdQ <= memRdata;
      end
      if (stb.capIo) begin
        if (!byteQ) begin
          holdQ <= ioRdata;
        end else if (stb.byteHi) begin
          holdQ[DATA_W-1 -: BYTE_W] <= ioRdata[BYTE_W-1:0];
        end else begin
          holdQ[BYTE_W-1:0] <= ioRdata[BYTE_W-1:0];
        end
      end
    end
  end

  assign outByte    = stb.byteHi ? holdQ[DATA_W-1 -: BYTE_W] : holdQ[BYTE_W-1:0];
  assign ioWdata    = byteQ ? DATA_W'(outByte) : holdQ;
  assign memWdata   = holdQ;
  assign memAddr    = addrQ;
  assign memPage    = dirQ ? rPageQ : wPageQ;
  assign sizeIsZero = (sizeQ == '0);
  assign sizeIsOne  = (sizeQ == CNT_W'(1));
  assign cfgMode    = modeQ;
  assign cfgMemToIo = dirQ;
  assign cfgByteDev = byteQ;
  assign readPage   = rPageQ;
  assign writePage  = wPageQ;

endmodule

// File: rtl/dmaio_control.sv
`timescale 1ns/1ps
module dmaio_control
  import dmaio_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWe,
  input  logic [1:0] regSel,
  input  logic      regStart,
  input  xferMode_e cfgMode,
  input  logic      cfgMemToIo,
  input  logic      cfgByteDev,
  input  logic      sizeIsZero,
  input  logic      sizeIsOne,
  input  logic      busGrant,
  input  logic      cpuIdle,
  input  logic      ioReady,
  output dpStrobe_t stb,
  output logic      busReq,
  output logic      busOwn,
  output logic      stealReq,
  output logic      memRe,
  output logic      memWe,
  output logic      ioRd,
  output logic      ioWr,
  output logic      busy,
  output logic      done
);

  chanState_e stateQ, stateN;
  logic ownQ, ownN;
  logic byteHiQ, byteHiN;
  logic doneQ, finishNow;
  logic isSteal, isInter, memOk, ioFire, wordDoneIo, startHit;

  assign isSteal    = (cfgMode == XM_STEAL);
  assign isInter    = (cfgMode == XM_IDLE);
  assign busy       = (stateQ != ST_IDLE);
  assign memOk      = isInter ? cpuIdle : (ownQ && busGrant);
  assign memRe      = (stateQ == ST_MEM) && memOk && cfgMemToIo;
  assign memWe      = (stateQ == ST_MEM) && memOk && !cfgMemToIo;
  assign ioFire     = (stateQ == ST_IO) && ioReady;
  assign ioRd       = ioFire && !cfgMemToIo;
  assign ioWr       = ioFire && cfgMemToIo;
  assign wordDoneIo = ioFire && (!cfgByteDev || byteHiQ);
  assign busReq     = (stateQ == ST_REQ) || ownQ;
  assign stealReq   = busReq && isSteal;
  assign busOwn     = ownQ;
  assign done       = doneQ;
  assign startHit   = regWe && (regSel == SEL_CTRL) && regStart && !busy;

  assign stb.advance = memRe || memWe;
  assign stb.capMem  = (stateQ == ST_CAP);
  assign stb.capIo   = ioRd;
  assign stb.byteHi  = byteHiQ;
  assign stb.cfgWrEn = !busy;

  always_comb begin
    stateN    = stateQ;
    ownN      = ownQ;
    byteHiN   = byteHiQ;
    finishNow = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (startHit) stateN = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        if (sizeIsZero)                  finishNow = 1'b1;
        else if (isInter)                stateN = cfgMemToIo ? ST_MEM : ST_IO;
        else if (isSteal && !cfgMemToIo) stateN = ST_IO;
        else                             stateN = ST_REQ;
      end
      ST_REQ: begin
        if (busGrant) begin
          ownN   = 1'b1;
          stateN = (cfgMemToIo || isSteal) ? ST_MEM : ST_IO;
        end
      end
      ST_MEM: begin
        if (memRe) begin
          stateN = ST_CAP;
        end else if (memWe) begin
          if (sizeIsOne) begin
            finishNow = 1'b1;
          end else begin
            if (isSteal) ownN = 1'b0;
            stateN = ST_IO;
          end
        end
      end
      ST_CAP: begin
        if (isSteal) ownN = 1'b0;
        stateN = ST_IO;
      end
      ST_IO: begin
        if (ioFire) byteHiN = cfgByteDev && !byteHiQ;
        if (wordDoneIo) begin
          if (cfgMemToIo && sizeIsZero) finishNow = 1'b1;
          else                          stateN = isSteal ? ST_REQ : ST_MEM;
        end
      end
      default: stateN = ST_IDLE;
    endcase
    if (finishNow) begin
      stateN  = ST_IDLE;
      ownN    = 1'b0;
      byteHiN = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      ownQ    <= 1'b0;
      byteHiQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      stateQ  <= stateN;
      ownQ    <= ownN;
      byteHiQ <= byteHiN;
      doneQ   <= finishNow;
    end
  end

endmodule

// File: rtl/dmaio_chan.sv
`timescale 1ns/1ps
module dmaio_chan
  import dmaio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busOwn,
  output logic              stealReq,
  input  logic              cpuIdle,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PAGE_W-1:0] memPage,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              ioReady,
  output logic              ioRd,
  output logic              ioWr,
  output logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              busy,
  output logic              done
);

  dpStrobe_t         stb;
  xferMode_e         cfgMode;
  logic              cfgMemToIo, cfgByteDev, sizeIsZero, sizeIsOne;
  logic [PAGE_W-1:0] readPage, writePage;

  dmaio_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .stb       (stb),
    .memRdata  (memRdata),
    .ioRdata   (ioRdata),
    .memAddr   (memAddr),
    .memPage   (memPage),
    .memWdata  (memWdata),
    .ioWdata   (ioWdata),
    .sizeIsZero(sizeIsZero),
    .sizeIsOne (sizeIsOne),
    .cfgMode   (cfgMode),
    .cfgMemToIo(cfgMemToIo),
    .cfgByteDev(cfgByteDev),
    .readPage  (readPage),
    .writePage (writePage)
  );

  dmaio_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regSel    (regSel),
    .regStart  (regWdata[CF_START]),
    .cfgMode   (cfgMode),
    .cfgMemToIo(cfgMemToIo),
    .cfgByteDev(cfgByteDev),
    .sizeIsZero(sizeIsZero),
    .sizeIsOne (sizeIsOne),
    .busGrant  (busGrant),
    .cpuIdle   (cpuIdle),
    .ioReady   (ioReady),
    .stb       (stb),
    .busReq    (busReq),
    .busOwn    (busOwn),
    .stealReq  (stealReq),
    .memRe     (memRe),
    .memWe     (memWe),
    .ioRd      (ioRd),
    .ioWr      (ioWr),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: rtl/dmaio_chan_chk.sv
`timescale 1ns/1ps
module dmaio_chan_chk
  import dmaio_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGrant,
  input logic              busOwn,
  input logic              stealReq,
  input logic              cpuIdle,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PAGE_W-1:0] memPage,
  input logic              memRe,
  input logic              memWe,
  input logic              ioReady,
  input logic              ioRd,
  input logic              ioWr,
  input logic              busy,
  input logic              done,
  input xferMode_e         cfgMode,
  input logic [PAGE_W-1:0] readPage,
  input logic [PAGE_W-1:0] writePage
);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |=> memAddr == $past(memAddr) + ADDR_W'(1));

  assert_own_holds_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    busOwn |-> busReq);

  assert_steal_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    stealReq |-> busReq && cfgMode == XM_STEAL);

  assert_idle_cycles_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((memRe || memWe) && cfgMode == XM_IDLE) |-> cpuIdle && !busReq);

  assert_bus_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((memRe || memWe) && cfgMode != XM_IDLE) |-> busOwn && busGrant);

  assert_write_page_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memPage == writePage);

  assert_read_page_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> memPage == readPage);

  assert_io_ready_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd || ioWr) |-> ioReady && !(ioRd && ioWr));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !busReq && !busOwn);

endmodule

bind dmaio_chan dmaio_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busGrant (busGrant),
  .busOwn   (busOwn),
  .stealReq (stealReq),
  .cpuIdle  (cpuIdle),
  .memAddr  (memAddr),
  .memPage  (memPage),
  .memRe    (memRe),
  .memWe    (memWe),
  .ioReady  (ioReady),
  .ioRd     (ioRd),
  .ioWr     (ioWr),
  .busy     (busy),
  .done     (done),
  .cfgMode  (cfgMode),
  .readPage (readPage),
  .writePage(writePage)
);

// File: tb/dmaio_chan_test.sv
`timescale 1ns/1ps
module dmaio_chan_test;
  import dmaio_pkg::*;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 16;

  typedef struct packed {
    logic [1:0] mode;
    logic       dir;
    logic       byteDev;
    logic [5:0] addr;
    logic [4:0] size;
    logic [3:0] rPg;
    logic [3:0] wPg;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 6'd4,  5'd5, 4'd1,  4'd3},
    '{2'd0, 1'b1, 1'b1, 6'd10, 5'd4, 4'd5,  4'd2},
    '{2'd1, 1'b0, 1'b1, 6'd20, 5'd3, 4'd7,  4'd9},
    '{2'd1, 1'b1, 1'b0, 6'd30, 5'd4, 4'd12, 4'd6},
    '{2'd2, 1'b0, 1'b0, 6'd40, 5'd3, 4'd0,  4'd14},
    '{2'd2, 1'b1, 1'b1, 6'd50, 5'd3, 4'd11, 4'd4},
    '{2'd3, 1'b0, 1'b1, 6'd56, 5'd2, 4'd8,  4'd15}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          regWe = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [DW-1:0] regWdata = '0;
  logic          busReq, busOwn, stealReq, memRe, memWe, ioRd, ioWr, busy, done;
  logic          busGrant = 1'b0;
  logic          cpuIdle, ioReady;
  logic [AW-1:0] memAddr;
  logic [PAGE_W-1:0] memPage;
  logic [DW-1:0] memWdata, ioWdata, ioRdata;
  logic [DW-1:0] memRdata = '0;

  dmaio_chan #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busReq(busReq), .busGrant(busGrant), .busOwn(busOwn), .stealReq(stealReq),
    .cpuIdle(cpuIdle), .memAddr(memAddr), .memPage(memPage), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata), .ioReady(ioReady),
    .ioRd(ioRd), .ioWr(ioWr), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] ioVal(input int k);
    return {8'(k) ^ 8'h5A, 8'(k) + 8'h11};
  endfunction

  function automatic logic [15:0] memInit(input int a);
    return {8'(a) ^ 8'h3C, 8'(a) + 8'h70};
  endfunction

  logic [DW-1:0] mem [64];
  logic [DW-1:0] sink [64];
  int tick = 0;
  int srcIdx = 0, sinkCnt = 0, memWeCnt = 0, ioCnt = 0, tenures = 0;
  int stealCyc = 0, reqCyc = 0, doneCnt = 0, pageBad = 0, idleBad = 0;
  int busBad = 0, rdyBad = 0;
  logic clr = 1'b0, preload = 1'b0, prevOwn = 1'b0, interMode = 1'b0;
  logic [PAGE_W-1:0] expPage = '0;
  int total = 0, bad = 0;

  assign ioReady = (tick % 5) != 2;
  assign cpuIdle = (tick % 3) == 0;
  assign ioRdata = ioVal(srcIdx);

  always @(posedge clk) begin
    tick     <= tick + 1;
    busGrant <= rstN ? busReq : 1'b0;
    prevOwn  <= busOwn;
    if (preload) begin
      for (int i = 0; i < 64; i++) mem[i] <= memInit(i);
    end else if (memWe) begin
      mem[memAddr[5:0]] <= memWdata;
    end
    if (memRe) memRdata <= mem[memAddr[5:0]];
    if (clr) begin
      srcIdx <= 0; sinkCnt <= 0; memWeCnt <= 0; ioCnt <= 0; tenures <= 0;
      stealCyc <= 0; reqCyc <= 0; doneCnt <= 0; pageBad <= 0; idleBad <= 0;
      busBad <= 0; rdyBad <= 0;
    end else begin
      if (ioRd) srcIdx <= srcIdx + 1;
      if (ioWr) begin
        sink[sinkCnt[5:0]] <= ioWdata;
        sinkCnt <= sinkCnt + 1;
      end
      if (memWe) memWeCnt <= memWeCnt + 1;
      if (ioRd || ioWr) ioCnt <= ioCnt + 1;
      if (busOwn && !prevOwn) tenures <= tenures + 1;
      if (stealReq) stealCyc <= stealCyc + 1;
      if (busReq) reqCyc <= reqCyc + 1;
      if (done) doneCnt <= doneCnt + 1;
      if ((memRe || memWe) && memPage != expPage) pageBad <= pageBad + 1;
      if ((memRe || memWe) && interMode && !cpuIdle) idleBad <= idleBad + 1;
      if ((memRe || memWe) && !interMode && !(busOwn && busGrant)) busBad <= busBad + 1;
      if ((ioRd || ioWr) && (!ioReady || (ioRd && ioWr))) rdyBad <= rdyBad + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [DW-1:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic clearModels();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic loadMem();
    @(negedge clk); preload = 1'b1;
    @(negedge clk); preload = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000 && doneCnt == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] ctrlWord(input vec_t v);
    return {1'b1, 3'b000, v.byteDev, v.dir, v.mode, v.wPg, v.rPg};
  endfunction

  task automatic runVec(input vec_t v);
    int n, a;
    string dTag;
    n = int'(v.size);
    a = int'(v.addr);
    dTag = !v.byteDev ? "R9 word data" : (v.dir ? "R11 byte split" : "R10 byte pack");
    clearModels();
    loadMem();
    expPage = v.dir ? v.rPg : v.wPg;
    interMode = (v.mode == 2'd2);
    regWrite(SEL_ADDR, 16'(v.addr));
    regWrite(SEL_SIZE, 16'(v.size));
    regWrite(SEL_CTRL, ctrlWord(v));
    waitDone();
    check(doneCnt == 1, "R13 single done pulse", doneCnt, 1);
    check(!busy && !busReq && !busOwn, "R13 quiet after done", {busy, busReq, busOwn}, 0);
    check(ioCnt == n * (v.byteDev ? 2 : 1), dTag, ioCnt, n * (v.byteDev ? 2 : 1));
    check(pageBad == 0, "R8 page on strobes", pageBad, 0);
    check(busBad == 0, "R7 strobe without bus", busBad, 0);
    check(rdyBad == 0, "R12 strobe without ready", rdyBad, 0);
    case (v.mode)
      2'd1: begin
        check(tenures == n, "R5 one tenure per word", tenures, n);
        check(stealCyc > 0, "R5 steal flag seen", stealCyc, 1);
      end
      2'd2: begin
        check(reqCyc == 0, "R6 no bus request", reqCyc, 0);
        check(idleBad == 0, "R6 strobe outside idle", idleBad, 0);
      end
      default: begin
        check(tenures == 1, "R4 single tenure", tenures, 1);
        check(stealCyc == 0, "R5 steal flag absent", stealCyc, 0);
      end
    endcase
    if (!v.dir) begin
      check(memWeCnt == n, "R3 memory word count", memWeCnt, n);
      for (int i = 0; i < n; i++) begin
        logic [15:0] e;
        e = v.byteDev ? {ioVal(2*i+1) & 16'h00FF, 8'h00} | (ioVal(2*i) & 16'h00FF) : ioVal(i);
        if (v.byteDev) e = {ioVal(2*i+1)[7:0], ioVal(2*i)[7:0]};
        check(mem[(a+i) % 64] == e, dTag, mem[(a+i) % 64], e);
      end
    end else begin
      check(memWeCnt == 0, "R9 no memory write when reading", memWeCnt, 0);
      for (int i = 0; i < n; i++) begin
        logic [15:0] w;
        w = memInit(a + i);
        if (v.byteDev) begin
          check(sink[2*i] == {8'h00, w[7:0]}, dTag, sink[2*i], {8'h00, w[7:0]});
          check(sink[2*i+1] == {8'h00, w[15:8]}, dTag, sink[2*i+1], {8'h00, w[15:8]});
        end else begin
          check(sink[i] == w, dTag, sink[i], w);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R13 actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !busReq && !busOwn && !done, "R13 reset idle",
          {busy, busReq, busOwn, done}, 0);
    check(!memRe && !memWe && !ioRd && !ioWr, "R13 reset strobes",
          {memRe, memWe, ioRd, ioWr}, 0);

    for (int k = 0; k < NVEC; k++) runVec(VECS[k]);

    // R2: zero count finishes at once without a request
    clearModels();
    interMode = 1'b0;
    regWrite(SEL_SIZE, 16'd0);
    regWrite(SEL_CTRL, {1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 4'd2, 4'd1});
    repeat (6) @(negedge clk);
    check(doneCnt == 1, "R2 zero count done", doneCnt, 1);
    check(reqCyc == 0, "R2 zero count no request", reqCyc, 0);
    check(memWeCnt == 0 && ioCnt == 0, "R2 zero count no access", memWeCnt + ioCnt, 0);

    // R1 and R3: address write landing on the final memory write is ignored
    clearModels();
    loadMem();
    expPage = 4'd3;
    regWrite(SEL_ADDR, 16'd8);
    regWrite(SEL_SIZE, 16'd4);
    regWrite(SEL_CTRL, {1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 4'd3, 4'd1});
    for (int i = 0; i < 3000 && !(memWe && memWeCnt == 3); i++) @(negedge clk);
    regWe = 1'b1; regSel = SEL_ADDR; regWdata = 16'd40;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
    waitDone();
    for (int i = 0; i < 4; i++)
      check(mem[8+i] == ioVal(i), "R3 consecutive fill", mem[8+i], ioVal(i));
    check(mem[40] == memInit(40), "R1 busy write ignored", mem[40], memInit(40));
    clearModels();
    regWrite(SEL_SIZE, 16'd2);
    regWrite(SEL_CTRL, {1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 4'd3, 4'd1});
    waitDone();
    check(mem[12] == ioVal(0), "R3 continues after block", mem[12], ioVal(0));
    check(mem[13] == ioVal(1), "R3 continues after block", mem[13], ioVal(1));
    check(mem[40] == memInit(40), "R1 address kept", mem[40], memInit(40));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule